// File: doc/BRIEF.md
# FM Synthesizer Parameter Write Decoder

This block turns writes from a two-strobe host port into the per-channel and per-operator parameter arrays of an FM synthesizer. The synthesizer has 32 operator slots arranged as 8 channels. The host first writes a register address and then a data byte. The block keeps the accepted address and marks the data as pending for one full frame of 32 cycles. The data lands in a parameter entry only in the cycle in which the rotating cycle counter reaches that entry. This matches a time-multiplexed datapath in which each slot's storage can be written only while that slot is on the bus.

A mode input selects a second address map with these differences:
- The effective slot runs one cycle ahead of the counter.
- Addresses 0x00 to 0x07 reach a per-channel 8-bit ramp divider.
- Operator level keeps all eight bits.
- The routing/feedback/algorithm field commits through a four-stage delay.
- The coarse and fine pitch fields commit one cycle late.
- Test bit 4 wipes every parameter as its slot comes round.

A separate test register is written by data strobes that follow an address strobe to the test address.

Top module: `fm_regwr`

## Requirements
- R1: An address strobe is accepted when wdata[7:5] is not zero, or, in the alternate mode, when wdata[7:3] is zero. A rejected address strobe drops any previously held address, so the data strobes that follow change no parameter.
- R2: A data strobe after an accepted address marks the data pending for exactly 32 cycles. A new address strobe ends the pending state. No slot or channel parameter changes outside a pending window, a delayed commit, or a test wipe.
- R3: A slot write commits when addr[4:0] equals the effective slot. The group is addr[7:5], and the fields are taken from data as follows:
  - 2: detune = [6:4], multiplier = [3:0].
  - 3: level.
  - 4: key scaling = [7:6], attack = [4:0].
  - 5: modulation enable = [7], decay-1 = [4:0].
  - 6: detune-2 = [7:6], decay-2 = [4:0].
  - 7: sustain level = [7:4], release = [3:0].
- R4: Slot level stores data[6:0] with bit 7 cleared in normal mode. It stores all 8 bits in the alternate mode.
- R5: In normal mode, channel writes use addresses 0x20..0x3F, with the channel in addr[2:0] and the field in addr[4:3]:
  - 0: routing = [7:6], feedback = [5:3], algorithm = [2:0].
  - 1: coarse pitch = [6:0].
  - 2: fine pitch = data[7:2].
  - 3: pitch depth = [6:4], amplitude depth = [1:0].
- R6: In the alternate mode the effective slot is (cycle+1) mod 32. Address 0x00+ch writes the 8-bit ramp divider of channel ch. Address 0x38+ch writes the two depth fields of channel ch.
- R7: In the alternate mode, a write to 0x20+ch enters a 4-bit shift register. It commits 4 cycles later to channel (effective+4) mod 8, which is the addressed channel.
- R8: In the alternate mode, writes to 0x28+ch and 0x30+ch commit one cycle later to channel (effective+7) mod 8, which is the addressed channel.
- R9: The 8-bit test register is written by a data strobe whose last address strobe carried 0x01 in normal mode or 0x09 in the alternate mode.
- R10: In the alternate mode, while test bit 4 is set, every parameter is cleared when its slot or channel comes round, and host writes do not commit.
- R11: Reset clears every parameter, the test register and all pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_we | input | 1 | Address strobe |
| data_we | input | 1 | Data strobe |
| wdata | input | 8 | Write byte |
| alt_mode | input | 1 | Selects the alternate address map |
| cycle | input | 5 | Rotating slot counter |
| ch_ramp_o | output | NCH*8 | Ramp dividers |
| ch_rl_o | output | NCH*2 | Output routing |
| ch_fb_o | output | NCH*3 | Feedback |
| ch_conn_o | output | NCH*3 | Algorithm |
| ch_kc_o | output | NCH*7 | Coarse pitch |
| ch_kf_o | output | NCH*6 | Fine pitch |
| ch_pms_o | output | NCH*3 | Pitch mod depth |
| ch_ams_o | output | NCH*2 | Amplitude mod depth |
| sl_dt1_o | output | NSL*3 | Detune |
| sl_mul_o | output | NSL*4 | Multiplier |
| sl_tl_o | output | NSL*8 | Level |
| sl_ks_o | output | NSL*2 | Key scaling |
| sl_ar_o | output | NSL*5 | Attack rate |
| sl_am_o | output | NSL | Modulation enable |
| sl_d1r_o | output | NSL*5 | Decay-1 rate |
| sl_dt2_o | output | NSL*2 | Detune-2 |
| sl_d2r_o | output | NSL*5 | Decay-2 rate |
| sl_d1l_o | output | NSL*4 | Sustain level |
| sl_rr_o | output | NSL*4 | Release rate |
| test_o | output | 8 | Test register |

## Verification
The bench builds the block with its default 32 slots and 8 channels. These are the only values the address map supports. With them, every slot and channel index can be reached through random addresses. Because the writes land at random offsets in the frame, the wrap of the effective slot past 31 and the wrap of the delayed channel indices past 7 both get exercised.

// File: rtl/fm_regwr_pkg.sv
package fm_regwr_pkg;

  typedef struct packed {
    logic [2:0] dt1;
    logic [3:0] mul;
    logic [7:0] tl;
    logic [1:0] ks;
    logic [4:0] ar;
    logic       am;
    logic [4:0] d1r;
    logic [1:0] dt2;
    logic [4:0] d2r;
    logic [3:0] d1l;
    logic [3:0] rr;
  } slot_prm_t;

  typedef struct packed {
    logic [7:0] ramp;
    logic [1:0] rl;
    logic [2:0] fb;
    logic [2:0] conn;
    logic [6:0] kc;
    logic [5:0] kf;
    logic [2:0] pms;
    logic [1:0] ams;
  } chan_prm_t;

  typedef enum logic [2:0] {
    GRP_DTMUL = 3'd2,
    GRP_LEVEL = 3'd3,
    GRP_KSAR  = 3'd4,
    GRP_AMD1  = 3'd5,
    GRP_DT2D2 = 3'd6,
    GRP_SLRR  = 3'd7
  } slot_grp_e;

  localparam logic [2:0] CH_PAGE = 3'b001;

  function automatic logic addr_accept(input logic [7:0] a, input logic alt);
    return (a[7:5] != 3'd0) || (alt && (a[7:3] == 5'd0));
  endfunction

  function automatic logic [7:0] level_value(input logic [7:0] d, input logic alt);
    return alt ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic [7:0] test_addr(input logic alt);
    return alt ? 8'h09 : 8'h01;
  endfunction

endpackage

// File: rtl/fm_regwr_port.sv
module fm_regwr_port import fm_regwr_pkg::*; #(
  parameter int NSL = 32,
  localparam int SW = $clog2(NSL)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_we,
  input  logic       data_we,
  input  logic [7:0] wdata,
  input  logic       alt_mode,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_data,
  output logic [7:0] mode_addr,
  output logic       addr_valid,
  output logic       data_ready,
  output logic [7:0] test_reg
);
  logic [SW-1:0] frame_cnt;
  logic          frame_end;

  assign frame_end = (frame_cnt == SW'(NSL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr   <= '0;
      reg_data   <= '0;
      mode_addr  <= '0;
      addr_valid <= 1'b0;
      data_ready <= 1'b0;
      frame_cnt  <= '0;
      test_reg   <= '0;
    end else if (addr_we) begin
      mode_addr  <= wdata;
      addr_valid <= addr_accept(wdata, alt_mode);
      data_ready <= 1'b0;
      if (addr_accept(wdata, alt_mode)) reg_addr <= wdata;
    end else if (data_we) begin
      reg_data <= wdata;
      if (mode_addr == test_addr(alt_mode)) test_reg <= wdata;
      if (addr_valid) begin
        data_ready <= 1'b1;
        frame_cnt  <= '0;
      end
    end else if (data_ready) begin
      frame_cnt <= frame_cnt + SW'(1);
      if (frame_end) data_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/fm_regwr_slots.sv
module fm_regwr_slots import fm_regwr_pkg::*; #(
  parameter int NSL = 32,
  localparam int SW = $clog2(NSL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alt_mode,
  input  logic            wipe,
  input  logic [SW-1:0]   eff_slot,
  input  logic            data_ready,
  input  logic [7:0]      reg_addr,
  input  logic [7:0]      reg_data,
  output logic            slot_we,
  output logic [NSL*3-1:0] sl_dt1_o,
  output logic [NSL*4-1:0] sl_mul_o,
  output logic [NSL*8-1:0] sl_tl_o,
  output logic [NSL*2-1:0] sl_ks_o,
  output logic [NSL*5-1:0] sl_ar_o,
  output logic [NSL-1:0]   sl_am_o,
  output logic [NSL*5-1:0] sl_d1r_o,
  output logic [NSL*2-1:0] sl_dt2_o,
  output logic [NSL*5-1:0] sl_d2r_o,
  output logic [NSL*4-1:0] sl_d1l_o,
  output logic [NSL*4-1:0] sl_rr_o
);
  slot_prm_t sl [NSL];
  slot_grp_e grp;

  assign grp     = slot_grp_e'(reg_addr[7:5]);
  assign slot_we = data_ready && !wipe && (reg_addr[SW-1:0] == eff_slot) &&
                   (reg_addr[7:5] >= 3'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSL; i++) sl[i] <= '0;
    end else if (wipe) begin
      sl[eff_slot] <= '0;
    end else if (slot_we) begin
      case (grp)
        GRP_DTMUL: begin sl[eff_slot].dt1 <= reg_data[6:4]; sl[eff_slot].mul <= reg_data[3:0]; end
        GRP_LEVEL: sl[eff_slot].tl <= level_value(reg_data, alt_mode);
        GRP_KSAR:  begin sl[eff_slot].ks  <= reg_data[7:6]; sl[eff_slot].ar  <= reg_data[4:0]; end
        GRP_AMD1:  begin sl[eff_slot].am  <= reg_data[7];   sl[eff_slot].d1r <= reg_data[4:0]; end
        GRP_DT2D2: begin sl[eff_slot].dt2 <= reg_data[7:6]; sl[eff_slot].d2r <= reg_data[4:0]; end
        GRP_SLRR:  begin sl[eff_slot].d1l <= reg_data[7:4]; sl[eff_slot].rr  <= reg_data[3:0]; end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NSL; i++) begin : g_out
    assign sl_dt1_o[i*3 +: 3] = sl[i].dt1;
    assign sl_mul_o[i*4 +: 4] = sl[i].mul;
    assign sl_tl_o[i*8 +: 8]  = sl[i].tl;
    assign sl_ks_o[i*2 +: 2]  = sl[i].ks;
    assign sl_ar_o[i*5 +: 5]  = sl[i].ar;
    assign sl_am_o[i]         = sl[i].am;
    assign sl_d1r_o[i*5 +: 5] = sl[i].d1r;
    assign sl_dt2_o[i*2 +: 2] = sl[i].dt2;
    assign sl_d2r_o[i*5 +: 5] = sl[i].d2r;
    assign sl_d1l_o[i*4 +: 4] = sl[i].d1l;
    assign sl_rr_o[i*4 +: 4]  = sl[i].rr;
  end
endmodule

// File: rtl/fm_regwr_chans.sv
module fm_regwr_chans import fm_regwr_pkg::*; #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH),
  localparam int RL_DLY = NCH / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alt_mode,
  input  logic            wipe,
  input  logic [CW-1:0]   eff_ch,
  input  logic            data_ready,
  input  logic [7:0]      reg_addr,
  input  logic [7:0]      reg_data,
  output logic            ch_pending,
  output logic [NCH*8-1:0] ch_ramp_o,
  output logic [NCH*2-1:0] ch_rl_o,
  output logic [NCH*3-1:0] ch_fb_o,
  output logic [NCH*3-1:0] ch_conn_o,
  output logic [NCH*7-1:0] ch_kc_o,
  output logic [NCH*6-1:0] ch_kf_o,
  output logic [NCH*3-1:0] ch_pms_o,
  output logic [NCH*2-1:0] ch_ams_o
);
  chan_prm_t         ch [NCH];
  logic [RL_DLY-1:0] dly_rl;
  logic              dly_kc, dly_kf;
  logic [CW-1:0]     ch_late4, ch_late1;
  logic              norm_hit, ramp_hit, depth_hit, rl_hit, kc_hit, kf_hit;

  assign ch_late4 = eff_ch + CW'(RL_DLY);
  assign ch_late1 = eff_ch - CW'(1);

  assign norm_hit  = data_ready && !alt_mode && (reg_addr[7:5] == CH_PAGE) &&
                     (reg_addr[CW-1:0] == eff_ch);
  assign ramp_hit  = data_ready && alt_mode && (reg_addr == 8'(eff_ch));
  assign depth_hit = data_ready && alt_mode && (reg_addr == (8'h38 | 8'(eff_ch)));
  assign rl_hit    = data_ready && alt_mode && (reg_addr == (8'h20 | 8'(eff_ch)));
  assign kc_hit    = data_ready && alt_mode && (reg_addr == (8'h28 | 8'(eff_ch)));
  assign kf_hit    = data_ready && alt_mode && (reg_addr == (8'h30 | 8'(eff_ch)));
  assign ch_pending = (|dly_rl) || dly_kc || dly_kf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_rl <= '0;
      dly_kc <= 1'b0;
      dly_kf <= 1'b0;
    end else begin
      dly_rl <= {dly_rl[RL_DLY-2:0], rl_hit};
      dly_kc <= kc_hit;
      dly_kf <= kf_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) ch[i] <= '0;
    end else if (wipe) begin
      ch[eff_ch].ramp   <= '0;
      ch[eff_ch].pms    <= '0;
      ch[eff_ch].ams    <= '0;
      ch[ch_late4].rl   <= '0;
      ch[ch_late4].fb   <= '0;
      ch[ch_late4].conn <= '0;
      ch[ch_late1].kc   <= '0;
      ch[ch_late1].kf   <= '0;
    end else if (alt_mode) begin
      if (dly_rl[RL_DLY-1]) begin
        ch[ch_late4].rl   <= reg_data[7:6];
        ch[ch_late4].fb   <= reg_data[5:3];
        ch[ch_late4].conn <= reg_data[2:0];
      end
      if (dly_kc) ch[ch_late1].kc <= reg_data[6:0];
      if (dly_kf) ch[ch_late1].kf <= reg_data[7:2];
      if (ramp_hit) ch[eff_ch].ramp <= reg_data;
      if (depth_hit) begin
        ch[eff_ch].pms <= reg_data[6:4];
        ch[eff_ch].ams <= reg_data[1:0];
      end
    end else if (norm_hit) begin
      case (reg_addr[4:3])
        2'd0: begin
          ch[eff_ch].rl   <= reg_data[7:6];
          ch[eff_ch].fb   <= reg_data[5:3];
          ch[eff_ch].conn <= reg_data[2:0];
        end
        2'd1: ch[eff_ch].kc <= reg_data[6:0];
        2'd2: ch[eff_ch].kf <= reg_data[7:2];
        default: begin
          ch[eff_ch].pms <= reg_data[6:4];
          ch[eff_ch].ams <= reg_data[1:0];
        end
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign ch_ramp_o[i*8 +: 8] = ch[i].ramp;
    assign ch_rl_o[i*2 +: 2]   = ch[i].rl;
    assign ch_fb_o[i*3 +: 3]   = ch[i].fb;
    assign ch_conn_o[i*3 +: 3] = ch[i].conn;
    assign ch_kc_o[i*7 +: 7]   = ch[i].kc;
    assign ch_kf_o[i*6 +: 6]   = ch[i].kf;
    assign ch_pms_o[i*3 +: 3]  = ch[i].pms;
    assign ch_ams_o[i*2 +: 2]  = ch[i].ams;
  end
endmodule

// File: rtl/fm_regwr.sv
module fm_regwr #(
  parameter int NSL = 32,
  parameter int NCH = 8,
  localparam int SW = $clog2(NSL),
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_we,
  input  logic             data_we,
  input  logic [7:0]       wdata,
  input  logic             alt_mode,
  input  logic [SW-1:0]    cycle,
  output logic [NCH*8-1:0] ch_ramp_o,
  output logic [NCH*2-1:0] ch_rl_o,
  output logic [NCH*3-1:0] ch_fb_o,
  output logic [NCH*3-1:0] ch_conn_o,
  output logic [NCH*7-1:0] ch_kc_o,
  output logic [NCH*6-1:0] ch_kf_o,
  output logic [NCH*3-1:0] ch_pms_o,
  output logic [NCH*2-1:0] ch_ams_o,
  output logic [NSL*3-1:0] sl_dt1_o,
  output logic [NSL*4-1:0] sl_mul_o,
  output logic [NSL*8-1:0] sl_tl_o,
  output logic [NSL*2-1:0] sl_ks_o,
  output logic [NSL*5-1:0] sl_ar_o,
  output logic [NSL-1:0]   sl_am_o,
  output logic [NSL*5-1:0] sl_d1r_o,
  output logic [NSL*2-1:0] sl_dt2_o,
  output logic [NSL*5-1:0] sl_d2r_o,
  output logic [NSL*4-1:0] sl_d1l_o,
  output logic [NSL*4-1:0] sl_rr_o,
  output logic [7:0]       test_o
);
  logic [7:0]    reg_addr, reg_data, mode_addr;
  logic          addr_valid, data_ready, wipe, slot_we, ch_pending;
  logic [SW-1:0] eff_slot;

  // The alternate map services each slot one cycle ahead of the counter.
  assign eff_slot = alt_mode ? cycle + SW'(1) : cycle;
  assign wipe     = alt_mode && test_o[4];

  fm_regwr_port #(.NSL(NSL)) u_port (
    .clk, .rst_n, .addr_we, .data_we, .wdata, .alt_mode,
    .reg_addr, .reg_data, .mode_addr, .addr_valid, .data_ready,
    .test_reg(test_o)
  );

  fm_regwr_slots #(.NSL(NSL)) u_slots (
    .clk, .rst_n, .alt_mode, .wipe, .eff_slot, .data_ready, .reg_addr, .reg_data,
    .slot_we, .sl_dt1_o, .sl_mul_o, .sl_tl_o, .sl_ks_o, .sl_ar_o, .sl_am_o,
    .sl_d1r_o, .sl_dt2_o, .sl_d2r_o, .sl_d1l_o, .sl_rr_o
  );

  fm_regwr_chans #(.NCH(NCH)) u_chans (
    .clk, .rst_n, .alt_mode, .wipe, .eff_ch(eff_slot[CW-1:0]), .data_ready,
    .reg_addr, .reg_data, .ch_pending, .ch_ramp_o, .ch_rl_o, .ch_fb_o,
    .ch_conn_o, .ch_kc_o, .ch_kf_o, .ch_pms_o, .ch_ams_o
  );
endmodule

// File: rtl/fm_regwr_chk.sv
module fm_regwr_chk #(
  parameter int NSL = 32,
  parameter int NCH = 8,
  localparam int SW = $clog2(NSL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_we,
  input logic             data_we,
  input logic [7:0]       wdata,
  input logic             alt_mode,
  input logic [SW-1:0]    eff_slot,
  input logic [7:0]       reg_addr,
  input logic [7:0]       mode_addr,
  input logic             addr_valid,
  input logic             data_ready,
  input logic             slot_we,
  input logic             ch_pending,
  input logic [7:0]       test_o,
  input logic [NSL*8-1:0] sl_tl_o,
  input logic [NCH*7-1:0] ch_kc_o
);
  logic [SW:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else if (addr_we || data_we) win_cnt <= '0;
    else if (data_ready) win_cnt <= win_cnt + 1'b1;
  end

  a_r1_reject_drops_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we && (wdata[7:5] == 3'd0) && !(alt_mode && wdata[4:3] == 2'd0) |=> !addr_valid);

  a_r2_ready_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(data_we) && $past(addr_valid));

  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> win_cnt < (SW+1)'(NSL));

  a_r2_no_stray_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready && !ch_pending && !(alt_mode && test_o[4]) |=> $stable(sl_tl_o) && $stable(ch_kc_o));

  a_r3_slot_match: assert property (@(posedge clk) disable iff (!rst_n)
    slot_we |-> data_ready && reg_addr[SW-1:0] == eff_slot);

  a_r9_test_write: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !addr_we && mode_addr == (alt_mode ? 8'h09 : 8'h01) |=> test_o == $past(wdata));
endmodule

bind fm_regwr fm_regwr_chk #(.NSL(NSL), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .data_we(data_we), .wdata(wdata),
  .alt_mode(alt_mode), .eff_slot(eff_slot), .reg_addr(reg_addr), .mode_addr(mode_addr),
  .addr_valid(addr_valid), .data_ready(data_ready), .slot_we(slot_we),
  .ch_pending(ch_pending), .test_o(test_o), .sl_tl_o(sl_tl_o), .ch_kc_o(ch_kc_o)
);

// File: tb/sim_fm_regwr.sv
module sim_fm_regwr;
  localparam int NSL = 32, NCH = 8;
  localparam int F_RAMP = 0, F_RL = 1, F_FB = 2, F_CONN = 3, F_KC = 4, F_KF = 5,
                 F_PMS = 6, F_AMS = 7, F_DT1 = 8, F_MUL = 9, F_TL = 10, F_KS = 11,
                 F_AR = 12, F_AM = 13, F_D1R = 14, F_DT2 = 15, F_D2R = 16,
                 F_D1L = 17, F_RR = 18;

  typedef struct { int f; int idx; int val; string req; } exp_t;

  logic clk = 0, rst_n = 0, addr_we = 0, data_we = 0, alt_mode = 0;
  logic [7:0] wdata = '0;
  logic [4:0] cyc;
  logic [NCH*8-1:0] ch_ramp_o; logic [NCH*2-1:0] ch_rl_o, ch_ams_o;
  logic [NCH*3-1:0] ch_fb_o, ch_conn_o, ch_pms_o; logic [NCH*7-1:0] ch_kc_o;
  logic [NCH*6-1:0] ch_kf_o;
  logic [NSL*3-1:0] sl_dt1_o; logic [NSL*4-1:0] sl_mul_o, sl_d1l_o, sl_rr_o;
  logic [NSL*8-1:0] sl_tl_o; logic [NSL*2-1:0] sl_ks_o, sl_dt2_o;
  logic [NSL*5-1:0] sl_ar_o, sl_d1r_o, sl_d2r_o; logic [NSL-1:0] sl_am_o;
  logic [7:0] test_o;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  exp_t sb[$];

  always #5 clk = ~clk;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0; else cyc <= cyc + 5'd1;

  fm_regwr u0 (.clk, .rst_n, .addr_we, .data_we, .wdata, .alt_mode, .cycle(cyc),
    .ch_ramp_o, .ch_rl_o, .ch_fb_o, .ch_conn_o, .ch_kc_o, .ch_kf_o, .ch_pms_o, .ch_ams_o,
    .sl_dt1_o, .sl_mul_o, .sl_tl_o, .sl_ks_o, .sl_ar_o, .sl_am_o, .sl_d1r_o,
    .sl_dt2_o, .sl_d2r_o, .sl_d1l_o, .sl_rr_o, .test_o);

  function automatic int get_field(int f, int i);
    case (f)
      F_RAMP: return int'(ch_ramp_o[i*8 +: 8]);  F_RL:  return int'(ch_rl_o[i*2 +: 2]);
      F_FB:   return int'(ch_fb_o[i*3 +: 3]);    F_CONN: return int'(ch_conn_o[i*3 +: 3]);
      F_KC:   return int'(ch_kc_o[i*7 +: 7]);    F_KF:  return int'(ch_kf_o[i*6 +: 6]);
      F_PMS:  return int'(ch_pms_o[i*3 +: 3]);   F_AMS: return int'(ch_ams_o[i*2 +: 2]);
      F_DT1:  return int'(sl_dt1_o[i*3 +: 3]);   F_MUL: return int'(sl_mul_o[i*4 +: 4]);
      F_TL:   return int'(sl_tl_o[i*8 +: 8]);    F_KS:  return int'(sl_ks_o[i*2 +: 2]);
      F_AR:   return int'(sl_ar_o[i*5 +: 5]);    F_AM:  return int'(sl_am_o[i]);
      F_D1R:  return int'(sl_d1r_o[i*5 +: 5]);   F_DT2: return int'(sl_dt2_o[i*2 +: 2]);
      F_D2R:  return int'(sl_d2r_o[i*5 +: 5]);   F_D1L: return int'(sl_d1l_o[i*4 +: 4]);
      default: return int'(sl_rr_o[i*4 +: 4]);
    endcase
  endfunction

  task automatic push(int f, int idx, int val, string req);
    exp_t e; e.f = f; e.idx = idx; e.val = val; e.req = req; sb.push_back(e);
  endtask

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor side: pops every expected entry once the writes have settled.
  task automatic drain();
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      check(e.req, $sformatf("field %0d idx %0d", e.f, e.idx), get_field(e.f, e.idx), e.val);
    end
  endtask

  task automatic wr_addr(logic [7:0] a);
    @(negedge clk); addr_we = 1; wdata = a; @(negedge clk); addr_we = 0;
  endtask
  task automatic wr_data(logic [7:0] d);
    @(negedge clk); data_we = 1; wdata = d; @(negedge clk); data_we = 0;
  endtask
  task automatic settle(); repeat (40) @(negedge clk); endtask

  // Driver side: one register write plus the expected result from the requirements.
  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    int g = int'(a[7:5]);
    int s = int'(a[4:0]);
    int c = int'(a[2:0]);
    repeat ($urandom % 8) @(negedge clk);
    wr_addr(a); wr_data(d);
    if (g >= 2) begin
      case (g)
        2: begin push(F_DT1, s, d[6:4], "R3"); push(F_MUL, s, d[3:0], "R3"); end
        3: push(F_TL, s, alt_mode ? int'(d) : int'(d[6:0]), "R4");
        4: begin push(F_KS, s, d[7:6], "R3"); push(F_AR, s, d[4:0], "R3"); end
        5: begin push(F_AM, s, d[7], "R3"); push(F_D1R, s, d[4:0], "R3"); end
        6: begin push(F_DT2, s, d[7:6], "R3"); push(F_D2R, s, d[4:0], "R3"); end
        default: begin push(F_D1L, s, d[7:4], "R3"); push(F_RR, s, d[3:0], "R3"); end
      endcase
    end else if (g == 1) begin
      case (a[4:3])
        2'd0: begin
          push(F_RL, c, d[7:6], alt_mode ? "R7" : "R5");
          push(F_FB, c, d[5:3], alt_mode ? "R7" : "R5");
          push(F_CONN, c, d[2:0], alt_mode ? "R7" : "R5");
        end
        2'd1: push(F_KC, c, d[6:0], alt_mode ? "R8" : "R5");
        2'd2: push(F_KF, c, d[7:2], alt_mode ? "R8" : "R5");
        default: begin
          push(F_PMS, c, d[6:4], alt_mode ? "R6" : "R5");
          push(F_AMS, c, d[1:0], alt_mode ? "R6" : "R5");
        end
      endcase
    end else if (alt_mode && a[7:3] == 5'd0) begin
      push(F_RAMP, c, d, "R6");
    end
    settle();
    drain();
  endtask

  function automatic logic [7:0] rnd_addr(bit alt);
    if (alt && ($urandom % 6 == 0)) return 8'($urandom % 8);
    return {3'(1 + $urandom % 7), 5'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    check("R11", "test reg", int'(test_o), 0);
    check("R11", "level any", int'(|sl_tl_o), 0);
    check("R11", "coarse pitch any", int'(|ch_kc_o), 0);

    // R3 R5: normal map, random fields at random frame offsets
    for (int i = 0; i < 24; i++) wr_reg(rnd_addr(0), 8'($urandom));
    // R4: normal level masks bit 7
    wr_reg(8'h67, 8'hFF);
    // R1: a rejected address drops the held one, so the data is lost
    wr_reg(8'h63, 8'h11);
    wr_addr(8'h10); wr_data(8'h22); settle();
    check("R1", "level slot3 after rejected addr", get_field(F_TL, 3), 8'h11);
    wr_addr(8'h05); wr_data(8'h33); settle();
    check("R1", "level slot3 after addr 0x05 in normal", get_field(F_TL, 3), 8'h11);
    // R9: test register at 0x01 in normal mode
    wr_addr(8'h01); wr_data(8'h6B); settle();
    check("R9", "test reg normal", int'(test_o), 8'h6B);
    wr_data(8'h00); settle();

    // R6 R7 R8: alternate map
    @(negedge clk); alt_mode = 1;
    for (int i = 0; i < 32; i++) wr_reg(rnd_addr(1), 8'($urandom));
    wr_reg(8'h03, 8'hA5);
    wr_reg(8'h25, 8'hDB);
    wr_reg(8'h2F, 8'h7E);
    wr_reg(8'h37, 8'hFC);
    wr_reg(8'h60, 8'hFF);
    wr_reg(8'h7F, 8'h9C);
    wr_reg(8'h3F, 8'h53);
    // R9 R10: test register at 0x09, bit 4 wipes everything
    wr_addr(8'h09); wr_data(8'h10); settle();
    check("R9", "test reg alternate", int'(test_o), 8'h10);
    check("R10", "level any", int'(|sl_tl_o), 0);
    check("R10", "ramp any", int'(|ch_ramp_o), 0);
    check("R10", "routing any", int'(|ch_rl_o | |ch_fb_o | |ch_conn_o), 0);
    check("R10", "pitch any", int'(|ch_kc_o | |ch_kf_o), 0);
    check("R10", "rates any", int'(|sl_ar_o | |sl_rr_o | |sl_d1r_o | |sl_d2r_o), 0);
    // R10: writes do not land while wiping
    wr_addr(8'h64); wr_data(8'h44); settle();
    check("R10", "level slot4 during wipe", get_field(F_TL, 4), 0);
    wr_addr(8'h09); wr_data(8'h00); settle();
    wr_reg(8'h64, 8'h44);
    wr_reg(8'h22, 8'h9A);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule